// File: doc/BRIEF.md
# State-Save Fault Qualifier

This block decides, for one state-save request, whether the instruction may go ahead or which single fault it must raise. It looks at the feature-support flags, two control-register bits, the four decoded prefix flags, the current processor mode and the effective address of the save area. The segment-limit comparison is done elsewhere, and its result comes in as one flag. The block returns a one-hot fault vector and a proceed flag.

A request is accepted whenever `req` is high. Its verdict appears one clock later, together with `res_valid`. The decode stage feeds it every cycle. The execution stage either starts the memory sequence, when `proceed` is set, or takes the fault that `fault` names. Only the highest-priority fault is reported. Invalid opcode comes first, then device-not-available, then the address faults. Among the address faults, misalignment is checked before any mode-specific fault.

Top module: `sq_save_qualifier`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `res_valid`, `fault` and `proceed` are all 0.
- R2: `res_valid` equals the value `req` had one clock earlier. In a cycle where `res_valid` is 0, both `fault` and `proceed` are 0.
- R3: The invalid-opcode fault (`fault` = 4'b1000) is raised when any of these holds: `feat_base` is 0, `feat_compact` is 0, `os_save_en` is 0, or any of `pfx_lock`, `pfx_opsize`, `pfx_rep`, `pfx_repne` is 1.
- R4: When R3 does not apply and `task_switched` is 1, the device-not-available fault (`fault` = 4'b0100) is raised.
- R5: When R3 and R4 do not apply and `ea[5:0]` is not zero, the general-protection fault (`fault` = 4'b0010) is raised, in every mode.
- R6: Long mode is selected by `cpu_mode` = 2'b10. In this mode an aligned address whose bits 63:47 are not all equal raises the stack fault (`fault` = 4'b0001) when `stack_seg` is 1, and the general-protection fault otherwise. `seg_limit_err` is ignored.
- R7: Real mode is selected by `cpu_mode` = 2'b00. In this mode an aligned address raises the general-protection fault when its last operand byte, `ea + opnd_len - 1`, lies above FFFFh. A zero `opnd_len` checks only `ea`. `stack_seg` and `seg_limit_err` are ignored.
- R8: Protected mode is selected by `cpu_mode` = 2'b01, and 2'b11 is treated the same way. In this mode an aligned address with `seg_limit_err` = 1 raises the stack fault when `stack_seg` is 1, and the general-protection fault otherwise.
- R9: At most one bit of `fault` is set. The bit positions are [3] invalid opcode, [2] device not available, [1] general protection and [0] stack fault.
- R10: `proceed` is 1 exactly when `res_valid` is 1 and `fault` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | A request to qualify is present this cycle |
| feat_base | input | 1 | Base state-save feature is supported |
| feat_compact | input | 1 | Compacted-save feature is supported |
| os_save_en | input | 1 | Control-register bit 18 of CR4: the OS has enabled state save |
| task_switched | input | 1 | Control-register bit 3 of CR0: a task switch has occurred |
| pfx_lock | input | 1 | A lock prefix is present |
| pfx_opsize | input | 1 | An operand-size (66h) prefix is present |
| pfx_rep | input | 1 | A repeat (F3h) prefix is present |
| pfx_repne | input | 1 | A repeat-not-equal (F2h) prefix is present |
| cpu_mode | input | 2 | 00 real, 01 protected, 10 long, 11 treated as protected |
| ea | input | ADDR_W | Effective address of the save area |
| opnd_len | input | LEN_W | Size of the operand in bytes |
| stack_seg | input | 1 | The access goes through the stack segment |
| seg_limit_err | input | 1 | The segment-limit check failed (protected mode) |
| res_valid | output | 1 | A verdict is present this cycle |
| fault | output | 4 | One-hot fault: [3] invalid opcode, [2] device not available, [1] general protection, [0] stack |
| proceed | output | 1 | The instruction may execute |

## Verification
The bench goes after the places where faults overlap.

- Requests that break several rules at once must report only the highest one. A design with the priority wrong would set two bits, or name the lower fault.
- Addresses that are both misaligned and non-canonical, or both misaligned and over the segment limit, must give the general-protection fault even when the stack segment is in use. A design that checked the mode first would wrongly report a stack fault.
- In real mode, operands that end exactly at FFFFh must pass, and operands that end one byte beyond it must fail. An off-by-one in the last-byte sum shows up at once.
- Addresses just inside and just outside the canonical range must be classified correctly. A design that tested the wrong bit span would let one of them through.
- The limit and stack flags are driven in modes where they must be ignored. A design that leaked them across modes would raise faults that should not appear.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic [1:0] {
        MODE_REAL = 2'b00,
        MODE_PROT = 2'b01,
        MODE_LONG = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    // Field order gives the one-hot bit positions: ud=[3] nm=[2] gp=[1] ss=[0]
    typedef struct packed {
        logic ud;
        logic nm;
        logic gp;
        logic ss;
    } fault_t;

    localparam int FAULT_W = $bits(fault_t);
    localparam int PFX_N   = 4;

    typedef struct packed {
        logic               feat_base;
        logic               feat_compact;
        logic               os_en;
        logic               ts;
        logic [PFX_N-1:0]   pfx;
    } ctl_t;

    typedef struct packed {
        logic gp;
        logic ss;
    } addr_flt_t;

    function automatic fault_t pick_fault(input logic ud, input logic nm,
                                          input addr_flt_t af);
        fault_t f;
        f = '0;
        if (ud)         f.ud = 1'b1;
        else if (nm)    f.nm = 1'b1;
        else if (af.gp) f.gp = 1'b1;
        else if (af.ss) f.ss = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/sq_ctl_check.sv
module sq_ctl_check
    import sq_pkg::*;
(
    input  ctl_t ctl,
    output logic ud,
    output logic nm
);
    logic feat_missing;
    logic bad_prefix;

    always_comb begin
        feat_missing = ~(ctl.feat_base & ctl.feat_compact & ctl.os_en);
        bad_prefix   = |ctl.pfx;
        ud           = feat_missing | bad_prefix;
        nm           = ctl.ts;
    end
endmodule

// File: rtl/sq_addr_check.sv
module sq_addr_check
    import sq_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int LIN_W    = 48,
    parameter int ALIGN_LG = 6,
    parameter int REAL_W   = 16,
    parameter int LEN_W    = 16
) (
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] ea,
    input  logic [LEN_W-1:0]  len,
    input  logic              stack_seg,
    input  logic              lim_err,
    output addr_flt_t         af
);
    localparam int SUM_W = ADDR_W + 1;
    localparam logic [SUM_W-1:0] REAL_MAX =
        {{(SUM_W-REAL_W){1'b0}}, {REAL_W{1'b1}}};

    logic             misaligned;
    logic             canonical;
    logic [SUM_W-1:0] last_byte;
    logic             real_over;

    assign misaligned = |ea[ALIGN_LG-1:0];

    generate
        if (LIN_W < ADDR_W) begin : g_canon
            logic [ADDR_W-LIN_W:0] upper;
            assign upper     = ea[ADDR_W-1:LIN_W-1];
            assign canonical = (&upper) | ~(|upper);
        end else begin : g_flat
            assign canonical = 1'b1;
        end
    endgenerate

    always_comb begin
        last_byte = {1'b0, ea} + SUM_W'(len);
        if (len != '0) last_byte = last_byte - SUM_W'(1);
        real_over = last_byte > REAL_MAX;
    end

    always_comb begin
        af = '0;
        if (misaligned) begin
            af.gp = 1'b1;
        end else begin
            unique case (mode)
                MODE_REAL: af.gp = real_over;
                MODE_LONG: begin
                    af.ss = ~canonical & stack_seg;
                    af.gp = ~canonical & ~stack_seg;
                end
                default: begin
                    af.ss = lim_err & stack_seg;
                    af.gp = lim_err & ~stack_seg;
                end
            endcase
        end
    end
endmodule

// File: rtl/sq_fault_pick.sv
module sq_fault_pick
    import sq_pkg::*;
(
    input  logic      ud,
    input  logic      nm,
    input  addr_flt_t af,
    output fault_t    flt,
    output logic      clear
);
    always_comb begin
        flt   = pick_fault(ud, nm, af);
        clear = ~(ud | nm | af.gp | af.ss);
    end
endmodule

// File: rtl/sq_save_qualifier.sv
module sq_save_qualifier
    import sq_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int LIN_W    = 48,
    parameter int ALIGN_LG = 6,
    parameter int REAL_W   = 16,
    parameter int LEN_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              feat_base,
    input  logic              feat_compact,
    input  logic              os_save_en,
    input  logic              task_switched,
    input  logic              pfx_lock,
    input  logic              pfx_opsize,
    input  logic              pfx_rep,
    input  logic              pfx_repne,
    input  logic [1:0]        cpu_mode,
    input  logic [ADDR_W-1:0] ea,
    input  logic [LEN_W-1:0]  opnd_len,
    input  logic              stack_seg,
    input  logic              seg_limit_err,
    output logic              res_valid,
    output logic [3:0]        fault,
    output logic              proceed
);
    ctl_t      ctl;
    logic      ud, nm, clear;
    addr_flt_t af;
    fault_t    flt_next, flt_q;

    assign ctl = '{feat_base:    feat_base,
                   feat_compact: feat_compact,
                   os_en:        os_save_en,
                   ts:           task_switched,
                   pfx:          {pfx_lock, pfx_opsize, pfx_rep, pfx_repne}};

    sq_ctl_check u_ctl (
        .ctl (ctl),
        .ud  (ud),
        .nm  (nm)
    );

    sq_addr_check #(
        .ADDR_W   (ADDR_W),
        .LIN_W    (LIN_W),
        .ALIGN_LG (ALIGN_LG),
        .REAL_W   (REAL_W),
        .LEN_W    (LEN_W)
    ) u_addr (
        .mode      (mode_e'(cpu_mode)),
        .ea        (ea),
        .len       (opnd_len),
        .stack_seg (stack_seg),
        .lim_err   (seg_limit_err),
        .af        (af)
    );

    sq_fault_pick u_pick (
        .ud    (ud),
        .nm    (nm),
        .af    (af),
        .flt   (flt_next),
        .clear (clear)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            flt_q     <= '0;
            proceed   <= 1'b0;
        end else begin
            res_valid <= req;
            flt_q     <= req ? flt_next : '0;
            proceed   <= req & clear;
        end
    end

    assign fault = flt_q;
endmodule

// File: rtl/sq_save_qualifier_chk.sv
module sq_save_qualifier_chk #(
    parameter int ADDR_W   = 64,
    parameter int ALIGN_LG = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              feat_base,
    input logic              feat_compact,
    input logic              os_save_en,
    input logic              task_switched,
    input logic              pfx_lock,
    input logic              pfx_opsize,
    input logic              pfx_rep,
    input logic              pfx_repne,
    input logic [ADDR_W-1:0] ea,
    input logic              res_valid,
    input logic [3:0]        fault,
    input logic              proceed
);
    logic ud_cond, ctl_ok;
    assign ud_cond = ~feat_base | ~feat_compact | ~os_save_en |
                     pfx_lock | pfx_opsize | pfx_rep | pfx_repne;
    assign ctl_ok  = ~ud_cond & ~task_switched;

    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req |=> res_valid);
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !req |=> !res_valid);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (fault == 4'b0000 && !proceed));
    assert_ud_raised_R3: assert property (@(posedge clk) disable iff (rst)
        (req && ud_cond) |=> fault == 4'b1000);
    assert_nm_raised_R4: assert property (@(posedge clk) disable iff (rst)
        (req && !ud_cond && task_switched) |=> fault == 4'b0100);
    assert_misalign_gp_R5: assert property (@(posedge clk) disable iff (rst)
        (req && ctl_ok && (|ea[ALIGN_LG-1:0])) |=> fault == 4'b0010);
    assert_single_fault_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fault));
    assert_proceed_clean_R10: assert property (@(posedge clk) disable iff (rst)
        proceed |-> (res_valid && fault == 4'b0000));
    assert_fault_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && fault == 4'b0000) |-> proceed);
endmodule

bind sq_save_qualifier sq_save_qualifier_chk #(
    .ADDR_W   (ADDR_W),
    .ALIGN_LG (ALIGN_LG)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req           (req),
    .feat_base     (feat_base),
    .feat_compact  (feat_compact),
    .os_save_en    (os_save_en),
    .task_switched (task_switched),
    .pfx_lock      (pfx_lock),
    .pfx_opsize    (pfx_opsize),
    .pfx_rep       (pfx_rep),
    .pfx_repne     (pfx_repne),
    .ea            (ea),
    .res_valid     (res_valid),
    .fault         (fault),
    .proceed       (proceed)
);

// File: tb/test_sq_save_qualifier.sv
module test_sq_save_qualifier;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        feat_base = 1'b1, feat_compact = 1'b1, os_save_en = 1'b1;
    logic        task_switched = 1'b0;
    logic        pfx_lock = 1'b0, pfx_opsize = 1'b0, pfx_rep = 1'b0, pfx_repne = 1'b0;
    logic [1:0]  cpu_mode = 2'b01;
    logic [63:0] ea = '0;
    logic [15:0] opnd_len = 16'd576;
    logic        stack_seg = 1'b0, seg_limit_err = 1'b0;
    logic        res_valid;
    logic [3:0]  fault;
    logic        proceed;

    int checks = 0;
    int errors = 0;

    // expectation for the outputs after the next rising edge
    bit         exp_valid = 1'b0;
    logic [3:0] exp_fault = 4'b0000;
    string      exp_tag   = "R2";

    always #10 clk = ~clk;

    sq_save_qualifier i_sq_save_qualifier (
        .clk(clk), .rst(rst), .req(req),
        .feat_base(feat_base), .feat_compact(feat_compact),
        .os_save_en(os_save_en), .task_switched(task_switched),
        .pfx_lock(pfx_lock), .pfx_opsize(pfx_opsize),
        .pfx_rep(pfx_rep), .pfx_repne(pfx_repne),
        .cpu_mode(cpu_mode), .ea(ea), .opnd_len(opnd_len),
        .stack_seg(stack_seg), .seg_limit_err(seg_limit_err),
        .res_valid(res_valid), .fault(fault), .proceed(proceed)
    );

    task automatic check(input string tag, input logic [7:0] act,
                         input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural reference: returns expected fault code and the rule that set it
    task automatic model(output logic [3:0] f, output string tag);
        longint unsigned a;
        longint unsigned hi;
        logic [64:0] last;
        a = ea;
        f = 4'b0000;
        tag = "R10";
        if (!feat_base || !feat_compact || !os_save_en ||
            pfx_lock || pfx_opsize || pfx_rep || pfx_repne) begin
            f = 4'b1000; tag = "R3";
        end else if (task_switched) begin
            f = 4'b0100; tag = "R4";
        end else if ((a % 64) != 0) begin
            f = 4'b0010; tag = "R5";
        end else if (cpu_mode == 2'b00) begin
            tag  = "R7";
            last = {1'b0, ea} + ((opnd_len == 0) ? 65'd0 : 65'(opnd_len) - 65'd1);
            if (last > 65'd65535) f = 4'b0010;
        end else if (cpu_mode == 2'b10) begin
            tag = "R6";
            hi  = a >> 47;
            if (!(hi == 0 || hi == 64'h1FFFF)) f = stack_seg ? 4'b0001 : 4'b0010;
        end else begin
            tag = "R8";
            if (seg_limit_err) f = stack_seg ? 4'b0001 : 4'b0010;
        end
    endtask

    task automatic compare_now();
        check("R2", {7'd0, res_valid}, {7'd0, exp_valid}, "res_valid");
        check(exp_tag, {4'd0, fault}, {4'd0, exp_fault}, "fault");
        check("R10", {7'd0, proceed},
              {7'd0, exp_valid && exp_fault == 4'b0000}, "proceed");
        check("R9", {7'd0, ($countones(fault) <= 1)}, 8'd1, "fault one-hot");
    endtask

    task automatic apply(input bit r, input bit fb, input bit fc, input bit os,
                         input bit ts, input logic [3:0] pfx, input logic [1:0] md,
                         input logic [63:0] a, input logic [15:0] ln,
                         input bit stk, input bit lim);
        @(negedge clk);
        compare_now();
        req = r; feat_base = fb; feat_compact = fc; os_save_en = os;
        task_switched = ts;
        {pfx_lock, pfx_opsize, pfx_rep, pfx_repne} = pfx;
        cpu_mode = md; ea = a; opnd_len = ln; stack_seg = stk; seg_limit_err = lim;
        exp_valid = r;
        if (r) model(exp_fault, exp_tag);
        else begin exp_fault = 4'b0000; exp_tag = "R2"; end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: outputs stay quiet through reset even with a request present
        req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1", {5'd0, res_valid, proceed, |fault}, 8'd0, "reset state");
        end
        @(negedge clk);
        rst = 1'b0;
        req = 1'b0;
        check("R1", {5'd0, res_valid, proceed, |fault}, 8'd0, "reset state");
        exp_valid = 1'b0; exp_fault = 4'b0000; exp_tag = "R1";

        // clean requests in every mode (R10)
        apply(1,1,1,1,0,4'b0000,2'b01,64'h0000_0000_0001_0040,16'd576,0,0);
        apply(1,1,1,1,0,4'b0000,2'b10,64'hFFFF_8000_0000_0000,16'd576,1,1);
        apply(1,1,1,1,0,4'b0000,2'b00,64'h0000_0000_0000_FDC0,16'd576,1,1);
        apply(0,1,1,1,0,4'b0000,2'b01,64'h40,16'd576,0,0);
        // R3: each feature/enable/prefix cause, with lower faults also present
        apply(1,0,1,1,1,4'b0000,2'b01,64'h41,16'd576,0,1);
        apply(1,1,0,1,0,4'b0000,2'b10,64'h40,16'd576,0,0);
        apply(1,1,1,0,1,4'b0000,2'b00,64'h3,16'd576,0,0);
        apply(1,1,1,1,0,4'b1000,2'b01,64'h40,16'd576,0,0);
        apply(1,1,1,1,0,4'b0100,2'b01,64'h40,16'd576,0,0);
        apply(1,1,1,1,1,4'b0010,2'b01,64'h40,16'd576,0,0);
        apply(1,1,1,1,0,4'b0001,2'b10,64'h8000_0000_0000_0000,16'd576,1,0);
        // R4: task-switched beats address faults
        apply(1,1,1,1,1,4'b0000,2'b10,64'h8000_0000_0000_0001,16'd576,1,0);
        apply(1,1,1,1,1,4'b0000,2'b01,64'h40,16'd576,0,0);
        // R5: misalignment in every mode, beating stack/limit/canonical faults
        apply(1,1,1,1,0,4'b0000,2'b01,64'h20,16'd576,1,1);
        apply(1,1,1,1,0,4'b0000,2'b10,64'h8000_0000_0000_0010,16'd576,1,0);
        apply(1,1,1,1,0,4'b0000,2'b00,64'h1,16'd576,0,0);
        apply(1,1,1,1,0,4'b0000,2'b11,64'h3F,16'd576,1,1);
        // R6: canonical edges and stack selection, limit flag ignored
        apply(1,1,1,1,0,4'b0000,2'b10,64'h0000_7FFF_FFFF_FFC0,16'd576,1,1);
        apply(1,1,1,1,0,4'b0000,2'b10,64'h0000_8000_0000_0000,16'd576,0,0);
        apply(1,1,1,1,0,4'b0000,2'b10,64'h0000_8000_0000_0000,16'd576,1,0);
        apply(1,1,1,1,0,4'b0000,2'b10,64'hFFFF_7FFF_FFFF_FFC0,16'd576,0,1);
        apply(1,1,1,1,0,4'b0000,2'b10,64'hFFFF_FFFF_FFFF_FFC0,16'd576,1,1);
        // R7: last byte exactly at FFFFh passes, one beyond fails
        apply(1,1,1,1,0,4'b0000,2'b00,64'hFDC0,16'd576,1,1);
        apply(1,1,1,1,0,4'b0000,2'b00,64'hFE00,16'd576,1,0);
        apply(1,1,1,1,0,4'b0000,2'b00,64'hFFC0,16'd64,0,0);
        apply(1,1,1,1,0,4'b0000,2'b00,64'hFFC0,16'd65,0,0);
        apply(1,1,1,1,0,4'b0000,2'b00,64'hFFC0,16'd0,0,0);
        apply(1,1,1,1,0,4'b0000,2'b00,64'h1_0000,16'd0,0,0);
        // R8: limit violation selects GP or SS, mode 11 treated as protected
        apply(1,1,1,1,0,4'b0000,2'b01,64'h80,16'd576,0,1);
        apply(1,1,1,1,0,4'b0000,2'b01,64'h80,16'd576,1,1);
        apply(1,1,1,1,0,4'b0000,2'b11,64'h80,16'd576,1,1);
        apply(1,1,1,1,0,4'b0000,2'b01,64'hFFFF_0000_0000_0000,16'd576,1,0);
        apply(0,0,0,0,1,4'b1111,2'b01,64'h1,16'd576,1,1);

        // mixed stimulus, faults made rare per field
        for (int n = 0; n < 400; n++) begin
            logic [63:0] a;
            logic [3:0]  p;
            int          pick;
            pick = int'($urandom_range(0, 5));
            case (pick)
                0: a = 64'($urandom_range(0, 65535));
                1: a = {$urandom, $urandom};
                2: a = 64'hFFFF_8000_0000_0000 | 64'({$urandom, $urandom} & 64'h7FFF_FFFF_FFFF);
                3: a = 64'h0000_7FFF_FFFF_FFC0 + 64'($urandom_range(0, 3) * 64);
                default: a = 64'($urandom_range(0, 1023)) << 6;
            endcase
            if ($urandom_range(0, 3) != 0) a[5:0] = 6'd0;
            p = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(1, 15)) : 4'b0000;
            apply($urandom_range(0, 7) != 0,
                  $urandom_range(0, 15) != 0, $urandom_range(0, 15) != 0,
                  $urandom_range(0, 15) != 0, $urandom_range(0, 9) == 0,
                  p, 2'($urandom_range(0, 3)), a,
                  16'($urandom_range(0, 2) == 0 ? $urandom_range(0, 1024) : 576),
                  $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
        end
        apply(0,1,1,1,0,4'b0000,2'b01,64'h0,16'd576,0,0);
        @(negedge clk);
        compare_now();
        summary();
        $finish;
    end
endmodule